// File: doc/BRIEF.md
# Single-Wire Debug Bit Transceiver

This block is the target-side bit engine for a half-duplex, open-drain debug link that uses one shared pin and runs on the target clock. The host begins every bit time by pulling the pin low. The block passes the pin through a synchroniser and a falling-edge detector. The cycle in which the detector fires is the perceived start of the bit, called cycle 0. Every later decision in that bit is timed from this point.

The direction is taken from `tx_mode` at the start of each bit. In receive mode the block tests the synchronised level at two points. One test checks that a logic 1 came back high in time, and the other samples the bit. In transmit mode the block sends the next bit of a byte it accepted earlier. For a 0 it holds the pin low. For a 1 it leaves the pin released and adds a one-cycle active-high speedup pulse. Received bits are assembled into bytes, most significant bit first, and are presented with a one-cycle valid strobe. Bytes to transmit are taken through a ready/valid handshake while the link is idle.

Top module: `dbg_wire_xcvr`

## Requirements
- R1: While `rst_n` is low, both pin drivers are off, `rx_valid`, `glitch_err` and `frame_err` are low, and no byte is held. `tx_ready` then simply follows `tx_mode`.
- R2: A host low pulse of at least 2 clock cycles on `pin_in` starts a bit time. Cycle 0 of that bit time is the cycle in which the synchronised pin shows the fall. This is 2 rising edges after the raw fall.
- R3: In receive mode, the bit value is the synchronised level in cycle 10. Bits enter the byte most significant bit first. When a bit completes a byte, `rx_data` carries the byte and `rx_valid` is high for exactly one cycle, in cycle 11 of that bit.
- R4: In receive mode, if the synchronised pin is still low in cycle 8 but high in cycle 10, the bit is stored as 0 and `glitch_err` is high for exactly one cycle, in cycle 11.
- R5: A falling edge seen in cycles 1 to 15 of a bit time does not start or restart a bit time. It raises `frame_err` for one cycle in the following cycle. A new bit time can start from cycle 16 onward.
- R6: `tx_ready` is high only when `tx_mode` is 1, no byte is held and no bit time is running. A transfer with `tx_valid` high moves `tx_data` into the block and drops `tx_ready`. `tx_ready` returns in cycle 16 of the byte's eighth bit.
- R7: In transmit mode, a 1 bit (the held byte's most significant unsent bit) leaves `pin_drive_low` off for the whole bit time. It drives `pin_drive_high` for exactly one cycle, in cycle 7.
- R8: In transmit mode, a 0 bit drives `pin_drive_low` in cycles 0 to 13, releases it from cycle 14, and never drives `pin_drive_high`. The pin the host samples 10 cycles after its own edge therefore carries the bit.
- R9: `pin_drive_low` and `pin_drive_high` are never high in the same cycle.
- R10: A bit time that starts in transmit mode with no byte held drives neither pin driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | 1 | Raw level of the shared debug pin, asynchronous |
| pin_drive_low | output | 1 | Pull the pin low (open-drain) |
| pin_drive_high | output | 1 | Speedup pulse, drives the pin high |
| tx_mode | input | 1 | 1 = send to host, 0 = receive from host, latched at bit start |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` is new |
| glitch_err | output | 1 | One-cycle strobe, late rising edge on a received bit |
| frame_err | output | 1 | One-cycle strobe, falling edge inside a bit time |

## Verification
Cycle n of a bit lies between the (n+2)th and (n+3)th rising edge after the host's raw fall. The level the block judges in cycle n is therefore the raw pin at edge n+1. The bench counts clock edges from its own fall and compares edge stamps, taken on falling clock edges, against these offsets:
- `glitch_err` and a byte-completing `rx_valid` are due at edge 13.
- A framing pulse caused by an extra fall released after edge 6 is due at edge 8.
- The speedup pulse is due at edge 9.
- The low drive of a 0 covers edges 2 to 15, which is 14 cycles.

Host-level samples are taken at edge 10, and a sample is only accepted when its stamp and its count match.

// File: rtl/dbg_xcvr_pkg.sv
`timescale 1ns/1ps
package dbg_xcvr_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // strobes decoded from the bit-time counter
  typedef struct packed {
    logic start;    // accepted falling edge, cycle 0
    logic in_bit;   // cycles 1 .. BIT_LEN-1
    logic at_spd;   // speedup cycle
    logic at_chk;   // late-rise check cycle
    logic at_smp;   // sample cycle
    logic low_win;  // cycles 1 .. LOW_END
    logic at_end;   // last cycle of the bit time
  } bit_evt_t;

endpackage

// File: rtl/dbg_pin_sync.sv
`timescale 1ns/1ps
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_s,
  output logic fall
);

  // STAGES synchroniser flops plus one history flop for the edge detector
  logic chain_q [STAGES+1];

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= pin_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign pin_s = chain_q[STAGES-1];
  assign fall  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/dbg_bit_timer.sv
`timescale 1ns/1ps
module dbg_bit_timer
  import dbg_xcvr_pkg::*;
#(
  parameter int BIT_LEN    = 16,
  parameter int SPEEDUP_AT = 7,
  parameter int CHECK_AT   = 8,
  parameter int SAMPLE_AT  = 10,
  parameter int LOW_END    = 13
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall,
  input  logic     tx_mode,
  output bit_evt_t evt,
  output dir_e     mode_q,
  output logic     frame_err
);

  localparam int CW = $clog2(BIT_LEN + 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  dir_e          mode_d;
  logic          frame_d, frame_q;
  logic          start;
  logic          last;

  assign start = fall & ~active_q;
  assign last  = active_q && (cnt_q == CW'(BIT_LEN - 1));

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = CW'(1);
      mode_d   = dir_e'(tx_mode);
    end else if (last) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      cnt_d    = cnt_q + CW'(1);
    end
    // an edge inside a running bit time is only reported
    frame_d = fall & active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= DIR_RX;
      frame_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
      frame_q  <= frame_d;
    end
  end

  assign evt.start   = start;
  assign evt.in_bit  = active_q;
  assign evt.at_spd  = active_q && (cnt_q == CW'(SPEEDUP_AT));
  assign evt.at_chk  = active_q && (cnt_q == CW'(CHECK_AT));
  assign evt.at_smp  = active_q && (cnt_q == CW'(SAMPLE_AT));
  assign evt.low_win = active_q && (cnt_q <= CW'(LOW_END));
  assign evt.at_end  = last;
  assign frame_err   = frame_q;

endmodule

// File: rtl/dbg_byte_shifter.sv
`timescale 1ns/1ps
module dbg_byte_shifter
  import dbg_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_bit,
  input  logic         at_chk,
  input  logic         at_smp,
  input  logic         at_end,
  input  dir_e         mode_q,
  input  logic         pin_s,
  input  logic         tx_mode,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         tx_full,
  output logic         lead_bit,
  output logic         bit_live,
  output logic         bit_val,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         glitch_err
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_d;
  logic          full_q, full_d;
  logic [CW-1:0] bc_q, bc_d;
  logic          live_q, live_d;
  logic          bval_q, bval_d;
  logic          late_q, late_d;
  logic [W-1:0]  rxd_q, rxd_d;
  logic          rxd_en;
  logic          rxv_d, rxv_q;
  logic          gl_d, gl_q;
  logic          smp;
  logic          load_fire;
  logic          rx_bit;

  assign tx_ready  = tx_mode & ~full_q & ~in_bit & ~start;
  assign load_fire = tx_valid & tx_ready;
  assign rx_bit    = (mode_q == DIR_RX);

  always_comb begin
    sh_d   = sh_q;
    full_d = full_q;
    bc_d   = bc_q;
    live_d = live_q;
    bval_d = bval_q;
    late_d = late_q;
    rxd_d  = rxd_q;
    rxd_en = 1'b0;
    rxv_d  = 1'b0;
    gl_d   = 1'b0;
    smp    = 1'b0;
    if (load_fire) begin
      sh_d   = tx_data;
      full_d = 1'b1;
      bc_d   = '0;
    end else if (start) begin
      late_d = 1'b0;
      if (tx_mode && full_q) begin
        live_d = 1'b1;
        bval_d = sh_q[W-1];
        sh_d   = {sh_q[W-2:0], 1'b0};
        bc_d   = bc_q + CW'(1);
      end else begin
        live_d = 1'b0;
      end
    end else if (at_end && live_q) begin
      live_d = 1'b0;
      if (bc_q == CW'(W)) begin
        full_d = 1'b0;
        bc_d   = '0;
      end
    end else if (at_chk && rx_bit) begin
      late_d = ~pin_s;
    end else if (at_smp && rx_bit) begin
      smp  = pin_s & ~late_q;
      gl_d = pin_s & late_q;
      sh_d = {sh_q[W-2:0], smp};
      if (bc_q == CW'(W - 1)) begin
        rxv_d  = 1'b1;
        rxd_d  = sh_d;
        rxd_en = 1'b1;
        bc_d   = '0;
      end else begin
        bc_d   = bc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      full_q <= 1'b0;
      bc_q   <= '0;
      live_q <= 1'b0;
      bval_q <= 1'b0;
      late_q <= 1'b0;
      rxv_q  <= 1'b0;
      gl_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      full_q <= full_d;
      bc_q   <= bc_d;
      live_q <= live_d;
      bval_q <= bval_d;
      late_q <= late_d;
      rxv_q  <= rxv_d;
      gl_q   <= gl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= '0;
    else if (rxd_en) rxd_q <= rxd_d;
  end

  assign tx_full    = full_q;
  assign lead_bit   = sh_q[W-1];
  assign bit_live   = live_q;
  assign bit_val    = bval_q;
  assign rx_data    = rxd_q;
  assign rx_valid   = rxv_q;
  assign glitch_err = gl_q;

endmodule

// File: rtl/dbg_wire_xcvr.sv
`timescale 1ns/1ps
module dbg_wire_xcvr
  import dbg_xcvr_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STG   = 2,
  parameter int BIT_LEN    = 16,
  parameter int SPEEDUP_AT = 7,
  parameter int CHECK_AT   = 8,
  parameter int SAMPLE_AT  = 10,
  parameter int LOW_END    = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_in,
  output logic         pin_drive_low,
  output logic         pin_drive_high,
  input  logic         tx_mode,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         glitch_err,
  output logic         frame_err
);

  logic     pin_s;
  logic     fall;
  bit_evt_t evt;
  dir_e     mode_q;
  logic     tx_full;
  logic     lead_bit;
  logic     bit_live;
  logic     bit_val;
  logic     send_now;
  logic     send_run;

  dbg_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_in),
    .pin_s   (pin_s),
    .fall    (fall)
  );

  dbg_bit_timer #(
    .BIT_LEN    (BIT_LEN),
    .SPEEDUP_AT (SPEEDUP_AT),
    .CHECK_AT   (CHECK_AT),
    .SAMPLE_AT  (SAMPLE_AT),
    .LOW_END    (LOW_END)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .tx_mode   (tx_mode),
    .evt       (evt),
    .mode_q    (mode_q),
    .frame_err (frame_err)
  );

  dbg_byte_shifter #(.W(W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (evt.start),
    .in_bit     (evt.in_bit),
    .at_chk     (evt.at_chk),
    .at_smp     (evt.at_smp),
    .at_end     (evt.at_end),
    .mode_q     (mode_q),
    .pin_s      (pin_s),
    .tx_mode    (tx_mode),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_full    (tx_full),
    .lead_bit   (lead_bit),
    .bit_live   (bit_live),
    .bit_val    (bit_val),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .glitch_err (glitch_err)
  );

  // cycle 0: take over the low level the moment the fall is seen
  assign send_now = evt.start & tx_mode & tx_full;
  // cycles 1..BIT_LEN-1: drive the bit latched at the start
  assign send_run = evt.in_bit & (mode_q == DIR_TX) & bit_live;

  assign pin_drive_low  = (send_now & ~lead_bit) |
                          (send_run & ~bit_val & evt.low_win);
  assign pin_drive_high = send_run & bit_val & evt.at_spd;

endmodule

// File: rtl/dbg_wire_xcvr_chk.sv
`timescale 1ns/1ps
module dbg_wire_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_drive_low,
  input logic pin_drive_high,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic glitch_err,
  input logic frame_err
);

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!pin_drive_low && !pin_drive_high && !rx_valid
                             && !glitch_err && !frame_err);
    end
  end

  // R9
  drv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_drive_low && pin_drive_high));

  // R7
  spd_one_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive_high |=> !pin_drive_high);

  // R8
  zero_no_spd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_drive_low) |-> !pin_drive_high);

  // R3
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  glitch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_err |=> !glitch_err);

  // R5
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R6
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

endmodule

bind dbg_wire_xcvr dbg_wire_xcvr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_drive_low  (pin_drive_low),
  .pin_drive_high (pin_drive_high),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .rx_valid       (rx_valid),
  .glitch_err     (glitch_err),
  .frame_err      (frame_err)
);

// File: tb/sim_dbg_wire_xcvr.sv
`timescale 1ns/1ps
module sim_dbg_wire_xcvr;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_low;
  logic       pin_in;
  logic       pin_drive_low, pin_drive_high;
  logic       tx_mode;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       glitch_err, frame_err;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // event monitor
  int dl_n, dl_first, dh_n, dh_first;
  int gl_n, gl_cyc, fr_n, fr_cyc, rv_n, rv_cyc;
  logic [7:0] rv_data;
  int smp_cyc;
  int smp_val;

  always #2.5 clk = ~clk;

  // open-drain wire: the host or the target can pull it low
  assign pin_in = ~(host_low | pin_drive_low);

  dbg_wire_xcvr u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .pin_in         (pin_in),
    .pin_drive_low  (pin_drive_low),
    .pin_drive_high (pin_drive_high),
    .tx_mode        (tx_mode),
    .tx_data        (tx_data),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .glitch_err     (glitch_err),
    .frame_err      (frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pin_drive_low)  begin if (dl_n == 0) dl_first = cyc; dl_n++; end
      if (pin_drive_high) begin if (dh_n == 0) dh_first = cyc; dh_n++; end
      if (glitch_err)     begin gl_cyc = cyc; gl_n++; end
      if (frame_err)      begin fr_cyc = cyc; fr_n++; end
      if (rx_valid)       begin rv_cyc = cyc; rv_data = rx_data; rv_n++; end
      if (cyc == smp_cyc) smp_val = int'(pin_in);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    dl_n = 0; dh_n = 0; gl_n = 0; fr_n = 0; rv_n = 0;
    dl_first = -1; dh_first = -1; gl_cyc = -1; fr_cyc = -1; rv_cyc = -1;
    smp_cyc = -1; smp_val = -1;
  endtask

  // kind 0: zero, 1: one, 2: late rise (glitch), 3: one with an extra fall
  task automatic host_rx_bit(input int kind, output int c0);
    @(posedge clk); #1;
    c0 = cyc;
    host_low = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); #1;
      case (kind)
        0: if (k == 12) host_low = 1'b0;
        1: if (k == 4)  host_low = 1'b0;
        2: if (k == 9)  host_low = 1'b0;
        default: begin
          if (k == 4) host_low = 1'b0;
          if (k == 5) host_low = 1'b1;
          if (k == 6) host_low = 1'b0;
        end
      endcase
    end
  endtask

  task automatic host_tx_bit(input string req, input logic exp_bit, input bit loaded);
    int c0;
    clear_mon();
    @(posedge clk); #1;
    c0 = cyc;
    smp_cyc = c0 + 10;
    host_low = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); #1;
      if (k == 2) host_low = 1'b0;
    end
    chk(req, "no framing error", fr_n, 0);
    if (!loaded) begin
      chk("R10", "low drives without byte", dl_n, 0);
      chk("R10", "high drives without byte", dh_n, 0);
    end else if (exp_bit) begin
      chk("R7", "speedup count", dh_n, 1);
      chk("R7", "speedup cycle", dh_first, c0 + 9);
      chk("R7", "low drive on a one", dl_n, 0);
      chk("R2", "host sample of one", smp_val, 1);
    end else begin
      chk("R8", "low drive length", dl_n, 14);
      chk("R8", "low drive first cycle", dl_first, c0 + 2);
      chk("R8", "speedup on a zero", dh_n, 0);
      chk("R8", "host sample of zero", smp_val, 0);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; host_low = 1'b0; tx_mode = 1'b0; tx_data = 8'h00; tx_valid = 1'b0;
    clear_mon();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "drive low in reset", int'(pin_drive_low), 0);
    chk("R1", "drive high in reset", int'(pin_drive_high), 0);
    chk("R1", "rx_valid in reset", int'(rx_valid), 0);
    chk("R1", "tx_ready rx mode", int'(tx_ready), 0);
    chk("R1", "rx_data in reset", int'(rx_data), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic test_rx_byte(input string req, input logic [7:0] pat,
                              input int gl_idx, input int fr_idx, input logic [7:0] expect_b);
    int c0, last_c0, gl_c0, fr_c0;
    gl_c0 = -1; fr_c0 = -1; last_c0 = 0;
    clear_mon();
    tx_mode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int kind;
      if (i == gl_idx)      kind = 2;
      else if (i == fr_idx) kind = 3;
      else                  kind = pat[7-i] ? 1 : 0;
      host_rx_bit(kind, c0);
      if (i == gl_idx) gl_c0 = c0;
      if (i == fr_idx) fr_c0 = c0;
      if (i == 7) last_c0 = c0;
    end
    chk(req, "rx_valid count", rv_n, 1);
    chk("R3", "rx_valid cycle", rv_cyc, last_c0 + 13);
    chk(req, "rx_data", int'(rv_data), int'(expect_b));
    if (gl_idx >= 0) begin
      chk("R4", "glitch count", gl_n, 1);
      chk("R4", "glitch cycle", gl_cyc, gl_c0 + 13);
    end else begin
      chk("R4", "no glitch", gl_n, 0);
    end
    if (fr_idx >= 0) begin
      chk("R5", "frame count", fr_n, 1);
      chk("R5", "frame cycle", fr_cyc, fr_c0 + 8);
    end else begin
      chk("R5", "no frame error", fr_n, 0);
    end
  endtask

  task automatic test_tx_no_byte();
    tx_mode = 1'b1;
    @(negedge clk);
    chk("R6", "ready when idle in tx mode", int'(tx_ready), 1);
    host_tx_bit("R10", 1'b0, 1'b0);
  endtask

  task automatic test_tx_byte(input logic [7:0] v);
    tx_mode = 1'b1;
    @(posedge clk); #1;
    tx_data = v; tx_valid = 1'b1;
    @(negedge clk);
    chk("R6", "ready before transfer", int'(tx_ready), 1);
    @(posedge clk); #1;
    tx_valid = 1'b0; tx_data = 8'h00;
    @(negedge clk);
    chk("R6", "ready after transfer", int'(tx_ready), 0);
    for (int i = 0; i < 8; i++) begin
      host_tx_bit("R6", v[7-i], 1'b1);
      if (i < 7) chk("R6", "ready mid byte", int'(tx_ready), 0);
    end
    @(negedge clk);
    chk("R6", "ready after last bit", int'(tx_ready), 1);
  endtask

  initial begin
    test_reset();
    test_rx_byte("R3", 8'hB4, -1, -1, 8'hB4);
    test_rx_byte("R3", 8'h5A, -1, -1, 8'h5A);
    test_rx_byte("R4", 8'hFF, 2, -1, 8'hDF);
    test_rx_byte("R5", 8'hFF, -1, 3, 8'hFF);
    test_tx_no_byte();
    test_tx_byte(8'h96);
    test_tx_byte(8'h0F);
    test_rx_byte("R3", 8'h81, -1, -1, 8'h81);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule